// File: doc/BRIEF.md
# Deferred-Fault Register File with Poison Tags

This block is a general-purpose register file in which every entry carries one extra tag bit marking its value as poisoned. It lets a machine hoist instructions above the point where they would normally run without taking the blame for faults they hit along the way. A speculative instruction that suffers a fatal-class fault does not raise it. It leaves a poisoned destination behind instead. The fault surfaces only when a committed instruction consumes that value, or when an explicit check operation at the instruction's home position inspects the register.

Each cycle the block accepts at most one executing operation and one check. The operation names two sources and one destination, and brings a result, a speculative flag, a fatal-fault flag and a resumable-fault flag. The block reads both sources combinationally and decides whether the operation raises a fatal exception, asks for fault service, or writes back. The write-back can store clean data, store a new poison tag, or pass a source's poison on to the destination. The check port reports whether its register is poisoned.

Top module: `poison_regfile`

## Requirements
- R1: A synchronous reset clears every data word to zero and every poison bit to 0.
- R2: A committed operation (opValid=1) that is not speculative and has no fault, no poisoned source and wrEn=1 stores `result` into the destination with the poison bit 0. The new value is visible on the read ports after the next rising edge.
- R3: A speculative operation with fatalFault=1 raises neither fatalExc nor serviceReq. It sets the destination's poison bit to 1 and the destination's data to zero.
- R4: A non-speculative operation that reads a source whose poison bit is 1 drives fatalExc=1 in the same cycle and writes nothing.
- R5: A speculative operation without faults that reads a poisoned source raises nothing and writes the destination with poison bit 1 and data zero.
- R6: resumeFault=1 drives serviceReq=1 for both speculative and non-speculative operations, and the destination is not written. When fatalExc is 1 in the same cycle, fatalExc takes precedence and serviceReq stays 0.
- R7: recoverReq equals chkValid AND the poison bit of register chkAddr, combinationally, independent of the operation port.
- R8: Register 0 always reads as zero with poison bit 0. Writes to it are ignored.
- R9: A non-speculative operation with fatalFault=1 drives fatalExc=1 and writes nothing.
- R10: rdDataA/B and rdPoisonA/B show the addressed entries combinationally and reflect the state before the current cycle's write.
- R11: With opValid=0, fatalExc and serviceReq stay 0 and no entry changes, whatever the other operation inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opSpec | input | 1 | The operation is speculative |
| srcA | input | ADDR_W | First source register index |
| srcB | input | ADDR_W | Second source register index |
| dst | input | ADDR_W | Destination register index |
| wrEn | input | 1 | The operation writes a destination |
| result | input | DATA_W | Result value to write |
| fatalFault | input | 1 | The operation hit a fatal-class fault |
| resumeFault | input | 1 | The operation hit a resumable fault |
| chkValid | input | 1 | A poison check is presented |
| chkAddr | input | ADDR_W | Register index to check |
| rdDataA | output | DATA_W | Data of srcA |
| rdDataB | output | DATA_W | Data of srcB |
| rdPoisonA | output | 1 | Poison bit of srcA |
| rdPoisonB | output | 1 | Poison bit of srcB |
| fatalExc | output | 1 | Fatal exception raised this cycle |
| serviceReq | output | 1 | Resumable fault passed on for service |
| recoverReq | output | 1 | Checked register is poisoned |

## Verification
The assertions assume the fault flags only matter while opValid is high, and that both sources are always meaningful. An operation that needs fewer sources names register 0 for the unused ones, since register 0 can never be poisoned. They also assume that reset is held for at least one edge before operations begin. The stimulus drives every input on the falling edge, holds opValid low around reset, and points each unused source at register 0. Some vectors deliberately load the idle-cycle fields with nonzero write requests, so that the idle rule is tested rather than merely assumed.

// File: rtl/poison_regfile_pkg.sv
package poison_regfile_pkg;

  // Write strobes that the control half hands to the storage half.
  typedef struct packed {
    logic commit;   // perform a write to the destination
    logic poison;   // the written entry carries the poison tag
  } wrStrobe_t;

  // How the control half classified the current operation.
  typedef enum logic [1:0] {
    OUT_IDLE    = 2'd0,
    OUT_WRITE   = 2'd1,
    OUT_FATAL   = 2'd2,
    OUT_SERVICE = 2'd3
  } opOutcome_t;

endpackage

// File: rtl/poison_regfile_ctrl.sv
module poison_regfile_ctrl
  import poison_regfile_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic              opSpec,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] dst,
  input  logic              fatalFault,
  input  logic              resumeFault,
  input  logic              srcPoisonA,
  input  logic              srcPoisonB,
  output logic              fatalExc,
  output logic              serviceReq,
  output wrStrobe_t         strobe
);

  logic       anySrcPoison;
  logic       dstIsZero;
  opOutcome_t outcome;

  assign anySrcPoison = srcPoisonA | srcPoisonB;
  assign dstIsZero    = (dst == '0);

  // Classification, highest priority first.
  always_comb begin
    outcome = OUT_IDLE;
    if (opValid) begin
      if (!opSpec && (anySrcPoison || fatalFault)) begin
        outcome = OUT_FATAL;
      end else if (resumeFault) begin
        outcome = OUT_SERVICE;
      end else if (wrEn) begin
        outcome = OUT_WRITE;
      end
    end
  end

  always_comb begin
    fatalExc      = (outcome == OUT_FATAL);
    serviceReq    = (outcome == OUT_SERVICE);
    strobe.commit = (outcome == OUT_WRITE) && !dstIsZero;
    strobe.poison = opSpec && (fatalFault || anySrcPoison);
  end

  // R6: exceptions are mutually exclusive
  p_one_exception_r6: assert property (@(posedge clk) disable iff (rst)
    !(fatalExc && serviceReq));

  // R3: speculative operations never raise a fatal exception
  p_spec_no_fatal_r3: assert property (@(posedge clk) disable iff (rst)
    (opValid && opSpec) |-> !fatalExc);

  // R4: no write-back when a fatal exception is raised
  p_no_commit_fatal_r4: assert property (@(posedge clk) disable iff (rst)
    fatalExc |-> !strobe.commit);

  // R11: an idle port raises nothing and writes nothing
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !opValid |-> (!fatalExc && !serviceReq && !strobe.commit));

  // R6: a resumable fault never writes back
  p_service_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (opValid && resumeFault) |-> !strobe.commit);

endmodule

// File: rtl/poison_regfile_dp.sv
module poison_regfile_dp
  import poison_regfile_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] dst,
  input  logic [DATA_W-1:0] result,
  input  logic [ADDR_W-1:0] srcA,
  input  logic [ADDR_W-1:0] srcB,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisonA,
  output logic              rdPoisonB,
  output logic              chkPoison
);

  logic [DATA_W-1:0] dataQ   [NUM_REGS];
  logic [NUM_REGS-1:0] poisonQ;
  logic [DATA_W-1:0] wrData;

  // A poisoned entry never keeps the faulting result.
  assign wrData = strobe.poison ? '0 : result;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign dataQ[i]   = '0;
      assign poisonQ[i] = 1'b0;
    end else begin : g_reg
      logic hit;
      assign hit = strobe.commit && (dst == ADDR_W'(i));
      always_ff @(posedge clk) begin
        if (rst) begin
          dataQ[i]   <= '0;
          poisonQ[i] <= 1'b0;
        end else if (hit) begin
          dataQ[i]   <= wrData;
          poisonQ[i] <= strobe.poison;
        end
      end
    end
  end

  // Out-of-range indices read as a clean zero.
  always_comb begin
    rdDataA   = '0;
    rdDataB   = '0;
    rdPoisonA = 1'b0;
    rdPoisonB = 1'b0;
    chkPoison = 1'b0;
    if (int'(srcA) < NUM_REGS) begin
      rdDataA   = dataQ[srcA];
      rdPoisonA = poisonQ[srcA];
    end
    if (int'(srcB) < NUM_REGS) begin
      rdDataB   = dataQ[srcB];
      rdPoisonB = poisonQ[srcB];
    end
    if (int'(chkAddr) < NUM_REGS) begin
      chkPoison = poisonQ[chkAddr];
    end
  end

  // R2/R3/R5: a committed write lands with the requested poison tag
  p_write_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && int'(dst) < NUM_REGS) |=>
      (poisonQ[$past(dst)] == $past(strobe.poison)));

  // R3: a poisoned entry holds zero data
  p_poison_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && strobe.poison && int'(dst) < NUM_REGS) |=>
      (dataQ[$past(dst)] == '0));

  // R11: without a commit strobe the poison tags hold
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !strobe.commit |=> $stable(poisonQ));

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import poison_regfile_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic              opSpec,
  input  logic [ADDR_W-1:0] srcA,
  input  logic [ADDR_W-1:0] srcB,
  input  logic [ADDR_W-1:0] dst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] result,
  input  logic              fatalFault,
  input  logic              resumeFault,
  input  logic              chkValid,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisonA,
  output logic              rdPoisonB,
  output logic              fatalExc,
  output logic              serviceReq,
  output logic              recoverReq
);

  wrStrobe_t strobe;
  logic      poisonA;
  logic      poisonB;
  logic      chkPoison;

  poison_regfile_dp #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .dst       (dst),
    .result    (result),
    .srcA      (srcA),
    .srcB      (srcB),
    .chkAddr   (chkAddr),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .rdPoisonA (poisonA),
    .rdPoisonB (poisonB),
    .chkPoison (chkPoison)
  );

  poison_regfile_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .opValid     (opValid),
    .opSpec      (opSpec),
    .wrEn        (wrEn),
    .dst         (dst),
    .fatalFault  (fatalFault),
    .resumeFault (resumeFault),
    .srcPoisonA  (poisonA),
    .srcPoisonB  (poisonB),
    .fatalExc    (fatalExc),
    .serviceReq  (serviceReq),
    .strobe      (strobe)
  );

  assign rdPoisonA  = poisonA;
  assign rdPoisonB  = poisonB;
  assign recoverReq = chkValid && chkPoison;

  // R8: register 0 never reads as poisoned
  p_r0_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (srcA == '0) |-> (!rdPoisonA && rdDataA == '0));

  // R7: a check without a request never asks for recovery
  p_chk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !chkValid |-> !recoverReq);

  // R1: the cycle after reset nothing is poisoned
  p_reset_clean_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rdPoisonA && !rdPoisonB));

endmodule

// File: tb/poison_regfile_bench.sv
module poison_regfile_bench;

  localparam int NUM_REGS = 16;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int NVEC     = 14;

  logic              clk = 1'b0;
  logic              rst;
  logic              opValid, opSpec, wrEn, fatalFault, resumeFault, chkValid;
  logic [ADDR_W-1:0] srcA, srcB, dst, chkAddr;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] rdDataA, rdDataB;
  logic              rdPoisonA, rdPoisonB, fatalExc, serviceReq, recoverReq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  poison_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_poison_regfile (
    .clk(clk), .rst(rst), .opValid(opValid), .opSpec(opSpec),
    .srcA(srcA), .srcB(srcB), .dst(dst), .wrEn(wrEn), .result(result),
    .fatalFault(fatalFault), .resumeFault(resumeFault),
    .chkValid(chkValid), .chkAddr(chkAddr),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .rdPoisonA(rdPoisonA),
    .rdPoisonB(rdPoisonB), .fatalExc(fatalExc), .serviceReq(serviceReq),
    .recoverReq(recoverReq)
  );

  typedef struct packed {
    logic v, s;
    logic [3:0] a, b, d;
    logic we;
    logic [31:0] res;
    logic flt, rsm, cv;
    logic [3:0] ca;
    logic eFat, eSvc, eRec;
    logic [31:0] eA, eB;
    logic ePA, ePB;
  } vec_t;

  // Expected outputs are those seen before the rising edge of that cycle.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,4'd0,4'd0,4'd1,1'b1,32'hA5,  1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0,1'b0}, // R2 write r1
    '{1'b1,1'b0,4'd1,4'd0,4'd2,1'b1,32'h1234,1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0, 32'hA5,  32'h0,   1'b0,1'b0}, // R2/R10
    '{1'b1,1'b1,4'd0,4'd0,4'd3,1'b1,32'hDEAD,1'b1,1'b0,1'b1,4'd3, 1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0,1'b0}, // R3 poison r3
    '{1'b1,1'b1,4'd3,4'd0,4'd4,1'b1,32'h77,  1'b0,1'b0,1'b1,4'd3, 1'b0,1'b0,1'b1, 32'h0,   32'h0,   1'b1,1'b0}, // R5/R7
    '{1'b1,1'b0,4'd2,4'd4,4'd5,1'b1,32'h9,   1'b0,1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0, 32'h1234,32'h0,   1'b0,1'b1}, // R4
    '{1'b0,1'b0,4'd5,4'd4,4'd0,1'b0,32'h0,   1'b0,1'b0,1'b1,4'd4, 1'b0,1'b0,1'b1, 32'h0,   32'h0,   1'b0,1'b1}, // R4 no write, R5
    '{1'b1,1'b0,4'd1,4'd0,4'd1,1'b1,32'hBAD, 1'b0,1'b1,1'b0,4'd0, 1'b0,1'b1,1'b0, 32'hA5,  32'h0,   1'b0,1'b0}, // R6 nonspec
    '{1'b1,1'b1,4'd2,4'd0,4'd2,1'b1,32'hBAD, 1'b0,1'b1,1'b0,4'd0, 1'b0,1'b1,1'b0, 32'h1234,32'h0,   1'b0,1'b0}, // R6 spec
    '{1'b1,1'b0,4'd0,4'd1,4'd3,1'b1,32'h3333,1'b0,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0, 32'h0,   32'hA5,  1'b0,1'b0}, // R2 clears poison
    '{1'b0,1'b0,4'd3,4'd2,4'd6,1'b1,32'h66,  1'b0,1'b0,1'b1,4'd3, 1'b0,1'b0,1'b0, 32'h3333,32'h1234,1'b0,1'b0}, // R11 idle write
    '{1'b1,1'b1,4'd6,4'd1,4'd0,1'b1,32'hDEAD,1'b1,1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0, 32'h0,   32'hA5,  1'b0,1'b0}, // R8 dst r0
    '{1'b0,1'b0,4'd0,4'd4,4'd0,1'b0,32'h0,   1'b0,1'b0,1'b1,4'd0, 1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0,1'b1}, // R8/R7
    '{1'b1,1'b0,4'd0,4'd0,4'd7,1'b1,32'h5,   1'b1,1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0, 32'h0,   32'h0,   1'b0,1'b0}, // R9
    '{1'b0,1'b0,4'd7,4'd3,4'd0,1'b0,32'h0,   1'b0,1'b0,1'b1,4'd7, 1'b0,1'b0,1'b0, 32'h0,   32'h3333,1'b0,1'b0}  // R9 no write
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    opValid = t.v; opSpec = t.s; srcA = t.a; srcB = t.b; dst = t.d;
    wrEn = t.we; result = t.res; fatalFault = t.flt; resumeFault = t.rsm;
    chkValid = t.cv; chkAddr = t.ca;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    rst = 1'b1;
    idle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #5;
    // R1: reset state
    check("R1 rdDataA after reset", rdDataA, 32'h0);
    check("R1 poison after reset", {31'b0, rdPoisonA | rdPoisonB}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #5;
      check($sformatf("R10 vec%0d rdDataA", i), rdDataA, VECS[i].eA);
      check($sformatf("R10 vec%0d rdDataB", i), rdDataB, VECS[i].eB);
      check($sformatf("R10 vec%0d rdPoisonA", i), {31'b0, rdPoisonA}, {31'b0, VECS[i].ePA});
      check($sformatf("R10 vec%0d rdPoisonB", i), {31'b0, rdPoisonB}, {31'b0, VECS[i].ePB});
      check($sformatf("R4/R9 vec%0d fatalExc", i), {31'b0, fatalExc}, {31'b0, VECS[i].eFat});
      check($sformatf("R6 vec%0d serviceReq", i), {31'b0, serviceReq}, {31'b0, VECS[i].eSvc});
      check($sformatf("R7 vec%0d recoverReq", i), {31'b0, recoverReq}, {31'b0, VECS[i].eRec});
    end

    // R6: speculative op with poisoned source and resumable fault -> service only
    @(negedge clk);
    idle(); opValid = 1'b1; opSpec = 1'b1; srcA = 4'd4; dst = 4'd8; wrEn = 1'b1;
    result = 32'h88; resumeFault = 1'b1;
    #5;
    check("R6 spec poisoned+resume service", {31'b0, serviceReq}, 32'h1);
    check("R6 spec poisoned+resume fatal", {31'b0, fatalExc}, 32'h0);

    // R6: non-speculative poisoned source with resumable fault -> fatal wins
    @(negedge clk);
    idle(); opValid = 1'b1; srcA = 4'd0; srcB = 4'd4; dst = 4'd9; wrEn = 1'b1;
    result = 32'h99; resumeFault = 1'b1;
    #5;
    check("R6 fatal precedence fatalExc", {31'b0, fatalExc}, 32'h1);
    check("R6 fatal precedence serviceReq", {31'b0, serviceReq}, 32'h0);

    // R6: neither destination was written
    @(negedge clk);
    idle(); srcA = 4'd8; srcB = 4'd9;
    #5;
    check("R6 r8 unwritten", {rdDataA[30:0], rdPoisonA}, 32'h0);
    check("R6 r9 unwritten", {rdDataB[30:0], rdPoisonB}, 32'h0);

    // R1: reset mid-run clears poison and data
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(); srcA = 4'd4; srcB = 4'd1; chkValid = 1'b1; chkAddr = 4'd4;
    #5;
    check("R1 r4 poison cleared", {31'b0, rdPoisonA}, 32'h0);
    check("R1 r1 data cleared", rdDataB, 32'h0);
    check("R1/R7 recover after reset", {31'b0, recoverReq}, 32'h0);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule